// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequence Decoder

This block sits behind the write port of a byte-wide NOR flash and turns bus write cycles into operations. It tracks the multi-write unlock-and-command sequences for byte program, whole-array erase, sector erase, identifier read, erase suspend, erase resume and reset. The result appears in three places: a mode output, one-cycle start strobes with their operands for an embedded program/erase engine, and a hold level that pauses that engine while an erase is suspended. The array, its high-voltage circuitry and its pulse timing are outside the block. The engine reports back through a done pulse and a fail pulse.

The bus is synchronous. A write is taken on every clock edge where chip enable and write enable are low and output enable is high. Any write that does not fit the sequence in progress sends the decoder back to reading the array. The set of writes the decoder accepts also depends on the operation in progress. A per-group lock input blocks program and erase of locked sectors. Such a request raises a one-cycle error pulse in place of a start strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, mode is read-array (0), rdata is 00h, and no strobe is raised.
- R2: An unlock write is AAh with the low eleven address bits equal to 555h, followed by 55h with the low eleven bits equal to 2AAh. A command write needs the low eleven bits equal to 555h. All higher address bits are ignored in these writes.
- R3: Unlock, A0h, then one write of (address, data) raises prog_start for one cycle on that write's edge, carries that address and data, and sets mode to program-busy (2).
- R4: Unlock, 80h, unlock, then 10h raises erase_start on that edge with a mask of every sector whose group is unlocked. Mode becomes erase-busy (3).
- R5: Unlock, 80h, unlock, then 30h selects the sector in address bits 19..16 and enters the erase window (mode 4). Each further lone write of 30h adds its sector and restarts the window. After WIN_CYCLES cycles with no write, erase_start is raised with the collected mask and mode becomes 3.
- R6: Any write that breaks a sequence returns mode to read-array, including from identifier mode (1). F0h after unlock also does this, and so does F0h on its own. Any other write during the erase window cancels the window and sends mode to read-array with no erase started.
- R7: In mode 2 every write is ignored. In mode 3 only B0h has an effect, and only for a sector erase. Mode holds until the engine reports done.
- R8: B0h during a sector erase or during its window enters suspended mode (5) with eng_hold high. A lone 30h resumes into mode 3, and also raises erase_start if the window had not yet closed. 30h has no effect in any other mode. B0h may be issued again after a resume.
- R9: In mode 5 a program to a sector outside the erase mask starts, with mode 2 and eng_hold still high, and returns to mode 5 on done. A program to a sector being erased is refused with prot_err. Other commands leave mode 5 unchanged.
- R10: F0h ends a busy operation only after eng_fail has been reported. Mode then becomes 0. Without a fail, F0h is ignored while busy.
- R11: In identifier mode, a read (chip enable and output enable low, write enable high) returns C2h when address bits 1..0 are 00 and D5h when they are 01. Any other read returns 00h. rdata is 00h outside identifier mode.
- R12: A cycle with output enable low or chip enable high or write enable high is not a write and does not advance or break a sequence.
- R13: Sector s belongs to lock group s/2 (address bits 19..17). A program to a locked group, or a sector-erase selection in a locked group, raises prot_err for one cycle with no start strobe. A whole-array erase skips locked sectors, and if every sector is locked it raises prot_err instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 20 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Identifier read data |
| grp_lock | input | 8 | Lock bit per two-sector group |
| eng_done | input | 1 | Engine finished the current operation |
| eng_fail | input | 1 | Engine exceeded its limits |
| mode | output | 3 | 0 read, 1 identifier, 2 program busy, 3 erase busy, 4 erase window, 5 suspended |
| prog_start | output | 1 | One-cycle program request |
| prog_addr | output | 20 | Program target address |
| prog_data | output | 8 | Program data |
| erase_start | output | 1 | One-cycle erase request |
| erase_mask | output | 16 | Sectors to erase |
| eng_hold | output | 1 | Pause the erase engine |
| prot_err | output | 1 | One-cycle refusal of a request |

## Verification
On every cycle the assertions check these properties: a start strobe always lands together with its busy mode, and a refusal never comes with a start. A busy program stays busy until done or an abort after a fail. Read and identifier modes change only on a qualified write. The erase window never outlives its limit, and a suspended program never targets an erasing sector. Only the bench's scenarios can show that the right operands go out and that exact unlock patterns are recognised with their upper address bits ignored. The same goes for the identifier codes, the mask built across several 30h writes, and the suspend, program, resume and re-suspend sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_ID    = 3'd1,
    M_PROG  = 3'd2,
    M_ERASE = 3'd3,
    M_EWIN  = 3'd4,
    M_SUSP  = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    Q_IDLE, Q_U1, Q_U2, Q_ES, Q_EU1, Q_EU2, Q_PW
  } seq_e;

  localparam logic [10:0] UNL_A1 = 11'h555;
  localparam logic [10:0] UNL_A2 = 11'h2AA;
  localparam logic [7:0]  UNL_D1 = 8'hAA;
  localparam logic [7:0]  UNL_D2 = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_SETUP = 8'h80;
  localparam logic [7:0]  CMD_ID    = 8'h90;
  localparam logic [7:0]  CMD_RESET = 8'hF0;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_SUSP  = 8'hB0;

  // true when the low address slice and data both match a pattern
  function automatic logic is_unlock(input logic [10:0] low, input logic [7:0] d,
                                     input logic [10:0] pa, input logic [7:0] pd);
    return (low == pa) && (d == pd);
  endfunction

  function automatic logic [7:0] id_code(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'hC2;
      2'b01:   return 8'hD5;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcd_bus_qual.sv
module fcd_bus_qual (
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr,
  output logic rd
);
  // a write needs CE and WE active with OE idle; any other mix inhibits it
  assign wr = !ce_n && !we_n && oe_n;
  assign rd = !ce_n && !oe_n && we_n;
endmodule

// File: rtl/fcd_seq_tracker.sv
module fcd_seq_tracker
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        hold_idle,
  input  logic [10:0] low_addr,
  input  logic [7:0]  data,
  output logic        ev_prog,
  output logic        ev_chip,
  output logic        ev_sector,
  output logic        ev_id,
  output logic        ev_f0,
  output logic        ev_b0,
  output logic        ev_d30,
  output logic        ev_bad
);
  seq_e st, st_nx;
  logic u1, u2, at_cmd;

  assign u1     = is_unlock(low_addr, data, UNL_A1, UNL_D1);
  assign u2     = is_unlock(low_addr, data, UNL_A2, UNL_D2);
  assign at_cmd = (low_addr == UNL_A1);

  always_comb begin
    st_nx     = st;
    ev_prog   = 1'b0;
    ev_chip   = 1'b0;
    ev_sector = 1'b0;
    ev_id     = 1'b0;
    ev_f0     = 1'b0;
    ev_b0     = 1'b0;
    ev_d30    = 1'b0;
    ev_bad    = 1'b0;
    if (wr) begin
      case (st)
        Q_IDLE: begin
          if (data == CMD_RESET)          ev_f0  = 1'b1;
          else if (data == CMD_SUSP)      ev_b0  = 1'b1;
          else if (data == CMD_SECT)      ev_d30 = 1'b1;
          else if (u1 && !hold_idle)      st_nx  = Q_U1;
          else                            ev_bad = 1'b1;
        end
        Q_U1: begin
          if (u2) st_nx = Q_U2;
          else begin st_nx = Q_IDLE; ev_bad = 1'b1; end
        end
        Q_U2: begin
          st_nx = Q_IDLE;
          if (!at_cmd)                    ev_bad = 1'b1;
          else if (data == CMD_PROG)      st_nx  = Q_PW;
          else if (data == CMD_SETUP)     st_nx  = Q_ES;
          else if (data == CMD_ID)        ev_id  = 1'b1;
          else if (data == CMD_RESET)     ev_f0  = 1'b1;
          else                            ev_bad = 1'b1;
        end
        Q_ES: begin
          if (u1) st_nx = Q_EU1;
          else begin st_nx = Q_IDLE; ev_bad = 1'b1; end
        end
        Q_EU1: begin
          if (u2) st_nx = Q_EU2;
          else begin st_nx = Q_IDLE; ev_bad = 1'b1; end
        end
        Q_EU2: begin
          st_nx = Q_IDLE;
          if (at_cmd && data == CMD_CHIP) ev_chip   = 1'b1;
          else if (data == CMD_SECT)      ev_sector = 1'b1;
          else                            ev_bad    = 1'b1;
        end
        Q_PW: begin
          st_nx   = Q_IDLE;
          ev_prog = 1'b1;
        end
        default: st_nx = Q_IDLE;
      endcase
    end
    if (hold_idle) st_nx = Q_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= Q_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/fcd_mode_ctrl.sv
module fcd_mode_ctrl
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SECT_W     = 4,
  parameter int WIN_CYCLES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            data,
  input  logic                  ev_prog,
  input  logic                  ev_chip,
  input  logic                  ev_sector,
  input  logic                  ev_id,
  input  logic                  ev_f0,
  input  logic                  ev_b0,
  input  logic                  ev_d30,
  input  logic                  ev_bad,
  input  logic [(1<<SECT_W)/2-1:0] grp_lock,
  input  logic                  eng_done,
  input  logic                  eng_fail,
  output logic [2:0]            mode_o,
  output logic                  busy,
  output logic                  fail_flag,
  output logic                  prog_start,
  output logic [ADDR_W-1:0]     prog_addr,
  output logic [7:0]            prog_data,
  output logic                  erase_start,
  output logic [(1<<SECT_W)-1:0] erase_mask,
  output logic                  eng_hold,
  output logic                  prot_err
);
  localparam int NSECT   = 1 << SECT_W;
  localparam int SEC_LSB = ADDR_W - SECT_W;
  localparam int CNT_W   = $clog2(WIN_CYCLES + 1);

  mode_e                mode;
  logic [CNT_W-1:0]     cnt;
  logic                 chip, pend, shold;
  logic [SECT_W-1:0]    ev_sec;
  logic [SECT_W-2:0]    ev_grp;
  logic                 ev_locked;
  logic [NSECT-1:0]     ev_onehot, unl_mask;

  assign ev_sec    = addr[ADDR_W-1:SEC_LSB];
  assign ev_grp    = ev_sec[SECT_W-1:1];
  assign ev_locked = grp_lock[ev_grp];
  assign ev_onehot = {{(NSECT-1){1'b0}}, 1'b1} << ev_sec;

  for (genvar s = 0; s < NSECT; s++) begin : g_unl
    assign unl_mask[s] = ~grp_lock[s/2];
  end

  assign mode_o   = mode;
  assign busy     = (mode == M_PROG) || (mode == M_ERASE) || (mode == M_EWIN);
  assign eng_hold = (mode == M_SUSP) || ((mode == M_PROG) && shold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode        <= M_READ;
      cnt         <= '0;
      chip        <= 1'b0;
      pend        <= 1'b0;
      shold       <= 1'b0;
      fail_flag   <= 1'b0;
      prog_start  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      erase_start <= 1'b0;
      erase_mask  <= '0;
      prot_err    <= 1'b0;
    end else begin
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      prot_err    <= 1'b0;
      if (eng_fail && (mode == M_PROG || mode == M_ERASE)) fail_flag <= 1'b1;
      case (mode)
        M_READ, M_ID: begin
          if (ev_prog) begin
            if (ev_locked) begin
              prot_err <= 1'b1;
              mode     <= M_READ;
            end else begin
              prog_start <= 1'b1;
              prog_addr  <= addr;
              prog_data  <= data;
              mode       <= M_PROG;
            end
          end else if (ev_chip) begin
            if (unl_mask == '0) begin
              prot_err <= 1'b1;
              mode     <= M_READ;
            end else begin
              erase_mask  <= unl_mask;
              chip        <= 1'b1;
              erase_start <= 1'b1;
              mode        <= M_ERASE;
            end
          end else if (ev_sector) begin
            if (ev_locked) begin
              prot_err <= 1'b1;
              mode     <= M_READ;
            end else begin
              erase_mask <= ev_onehot;
              chip       <= 1'b0;
              cnt        <= '0;
              mode       <= M_EWIN;
            end
          end else if (ev_id) begin
            mode <= M_ID;
          end else if (ev_f0 || ev_bad) begin
            mode <= M_READ;
          end
        end
        M_PROG: begin
          if (eng_done) begin
            mode      <= shold ? M_SUSP : M_READ;
            shold     <= 1'b0;
            fail_flag <= 1'b0;
          end else if (fail_flag && ev_f0) begin
            mode       <= M_READ;
            shold      <= 1'b0;
            pend       <= 1'b0;
            fail_flag  <= 1'b0;
            erase_mask <= '0;
          end
        end
        M_ERASE: begin
          if (eng_done || (fail_flag && ev_f0)) begin
            mode       <= M_READ;
            erase_mask <= '0;
            fail_flag  <= 1'b0;
          end else if (ev_b0 && !chip) begin
            mode <= M_SUSP;
            pend <= 1'b0;
          end
        end
        M_EWIN: begin
          if (wr) begin
            if (ev_d30) begin
              if (ev_locked) prot_err <= 1'b1;
              else           erase_mask <= erase_mask | ev_onehot;
              cnt <= '0;
            end else if (ev_b0) begin
              mode <= M_SUSP;
              pend <= 1'b1;
            end else begin
              mode       <= M_READ;
              erase_mask <= '0;
            end
          end else if (cnt == CNT_W'(WIN_CYCLES - 1)) begin
            erase_start <= 1'b1;
            mode        <= M_ERASE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        M_SUSP: begin
          if (ev_d30) begin
            mode <= M_ERASE;
            if (pend) begin
              erase_start <= 1'b1;
              pend        <= 1'b0;
            end
          end else if (ev_prog) begin
            if (ev_locked || erase_mask[ev_sec]) begin
              prot_err <= 1'b1;
            end else begin
              prog_start <= 1'b1;
              prog_addr  <= addr;
              prog_data  <= data;
              shold      <= 1'b1;
              mode       <= M_PROG;
            end
          end
        end
        default: mode <= M_READ;
      endcase
    end
  end
endmodule

// File: rtl/fcd_id_read.sv
module fcd_id_read
  import fcd_pkg::*;
(
  input  logic       rd,
  input  logic [2:0] mode,
  input  logic [1:0] sel,
  output logic [7:0] rdata
);
  always_comb rdata = (rd && mode == M_ID) ? id_code(sel) : 8'h00;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W     = 20,
  parameter int SECT_W     = 4,
  parameter int WIN_CYCLES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce_n,
  input  logic                       oe_n,
  input  logic                       we_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  input  logic [(1<<SECT_W)/2-1:0]   grp_lock,
  input  logic                       eng_done,
  input  logic                       eng_fail,
  output logic [2:0]                 mode,
  output logic                       prog_start,
  output logic [ADDR_W-1:0]          prog_addr,
  output logic [7:0]                 prog_data,
  output logic                       erase_start,
  output logic [(1<<SECT_W)-1:0]     erase_mask,
  output logic                       eng_hold,
  output logic                       prot_err
);
  logic wr_ok, rd_ok, busy, fail_flag;
  logic ev_prog, ev_chip, ev_sector, ev_id, ev_f0, ev_b0, ev_d30, ev_bad;

  fcd_bus_qual u_qual (
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wr(wr_ok), .rd(rd_ok)
  );

  fcd_seq_tracker u_seq (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok), .hold_idle(busy),
    .low_addr(addr[10:0]), .data(wdata),
    .ev_prog(ev_prog), .ev_chip(ev_chip), .ev_sector(ev_sector), .ev_id(ev_id),
    .ev_f0(ev_f0), .ev_b0(ev_b0), .ev_d30(ev_d30), .ev_bad(ev_bad)
  );

  fcd_mode_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .WIN_CYCLES(WIN_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ok), .addr(addr), .data(wdata),
    .ev_prog(ev_prog), .ev_chip(ev_chip), .ev_sector(ev_sector), .ev_id(ev_id),
    .ev_f0(ev_f0), .ev_b0(ev_b0), .ev_d30(ev_d30), .ev_bad(ev_bad),
    .grp_lock(grp_lock), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode_o(mode), .busy(busy), .fail_flag(fail_flag),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_mask(erase_mask),
    .eng_hold(eng_hold), .prot_err(prot_err)
  );

  fcd_id_read u_id (
    .rd(rd_ok), .mode(mode), .sel(addr[1:0]), .rdata(rdata)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int SECT_W     = 4,
  parameter int WIN_CYCLES = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr,
  input logic [7:0]              wdata,
  input logic [2:0]              mode,
  input logic                    fail_flag,
  input logic                    eng_done,
  input logic                    prog_start,
  input logic [SECT_W-1:0]       prog_sec,
  input logic                    erase_start,
  input logic [(1<<SECT_W)-1:0]  erase_mask,
  input logic                    eng_hold,
  input logic                    prot_err
);
  localparam int RUN_W = $clog2(WIN_CYCLES + 1) + 1;
  logic [RUN_W-1:0] win_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                          win_run <= '0;
    else if (mode != M_EWIN)             win_run <= '0;
    else if (wr && wdata == CMD_SECT)    win_run <= '0;
    else                                 win_run <= win_run + 1'b1;
  end

  // R3
  prog_start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> mode == M_PROG);

  // R4
  erase_start_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (mode == M_ERASE) && (erase_mask != '0));

  // R5
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_run <= RUN_W'(WIN_CYCLES));

  // R7
  prog_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PROG && !eng_done && !fail_flag) |=> mode == M_PROG);

  // R7
  erase_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && !eng_done && !fail_flag) |=> (mode == M_ERASE || mode == M_SUSP));

  // R9
  susp_prog_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start && eng_hold) |-> !erase_mask[prog_sec]);

  // R12
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && (mode == M_READ || mode == M_ID)) |=> $stable(mode));

  // R13
  prot_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> !prog_start && !erase_start);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start}));
endmodule

bind flash_cmd_decoder fcd_checker #(.SECT_W(SECT_W), .WIN_CYCLES(WIN_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr_ok), .wdata(wdata), .mode(mode),
  .fail_flag(fail_flag), .eng_done(eng_done), .prog_start(prog_start),
  .prog_sec(prog_addr[ADDR_W-1:ADDR_W-SECT_W]), .erase_start(erase_start),
  .erase_mask(erase_mask), .eng_hold(eng_hold), .prot_err(prot_err)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int WIN = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  grp_lock = 8'h04;
  logic eng_done = 1'b0, eng_fail = 1'b0;
  logic [7:0]  rdata;
  logic [2:0]  mode;
  logic        prog_start, erase_start, eng_hold, prot_err;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;
  logic [15:0] erase_mask;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.WIN_CYCLES(WIN)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .grp_lock(grp_lock),
    .eng_done(eng_done), .eng_fail(eng_fail), .mode(mode),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_mask(erase_mask),
    .eng_hold(eng_hold), .prot_err(prot_err)
  );

  typedef struct {
    int          kind;   // 0 program, 1 erase, 2 refusal
    logic [19:0] a;
    logic [7:0]  d;
    logic [15:0] m;
    string       req;
  } item_t;

  item_t exp_q[$];
  int vecs = 0;
  int fails = 0;

  function automatic void take(int k, logic [19:0] a, logic [7:0] d, logic [15:0] m);
    item_t it;
    vecs++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R6 unexpected strobe kind=%0d a=%h d=%h m=%h, expected none", k, a, d, m);
      return;
    end
    it = exp_q.pop_front();
    if (it.kind != k || (k == 0 && (it.a != a || it.d != d)) || (k == 1 && it.m != m)) begin
      fails++;
      $display("FAIL %s strobe kind=%0d a=%h d=%h m=%h, expected kind=%0d a=%h d=%h m=%h",
               it.req, k, a, d, m, it.kind, it.a, it.d, it.m);
    end
  endfunction

  // monitor: strobes set at a rising edge are compared at the next falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prog_start)  take(0, prog_addr, prog_data, 16'h0);
      if (erase_start) take(1, 20'h0, 8'h0, erase_mask);
      if (prot_err)    take(2, 20'h0, 8'h0, 16'h0);
    end
  end

  function automatic void push(int k, logic [19:0] a, logic [7:0] d, logic [15:0] m, string r);
    item_t it;
    it.kind = k; it.a = a; it.d = d; it.m = m; it.req = r;
    exp_q.push_back(it);
  endfunction

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  // cycle with write enable low but inhibited by OE low or CE high
  task automatic wr_inh(logic [19:0] a, logic [7:0] d, bit use_oe);
    @(negedge clk);
    we_n = 1'b0; addr = a; wdata = d;
    if (use_oe) begin ce_n = 1'b0; oe_n = 1'b0; end
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unl();
    wr(20'hF0555, 8'hAA);
    wr(20'h3A2AA, 8'h55);
  endtask

  task automatic cmd(logic [7:0] c);
    unl();
    wr(20'h00555, c);
  endtask

  task automatic prog(logic [19:0] a, logic [7:0] d);
    cmd(8'hA0);
    wr(a, d);
  endtask

  task automatic serase(logic [19:0] a);
    cmd(8'h80);
    unl();
    wr(a, 8'h30);
  endtask

  task automatic done();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic id_read(logic [19:0] a, logic [7:0] exp, string r);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    #1 chk(r, {8'h0, rdata}, {8'h0, exp});
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", {13'h0, mode}, 16'h0);
    chk("R1", {8'h0, rdata}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {13'h0, mode}, 16'h0);

    // R2 unlock with upper address bits set; R11 identifier codes
    cmd(8'h90);
    chk("R2", {13'h0, mode}, 16'h1);
    id_read(20'hABC00, 8'hC2, "R11");
    id_read(20'h55501, 8'hD5, "R11");
    id_read(20'h00002, 8'h00, "R11");
    wr(20'h00000, 8'hF0);
    chk("R6", {13'h0, mode}, 16'h0);
    id_read(20'h00000, 8'h00, "R11");

    // R6 broken second unlock; bad write in identifier mode
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55); wr(20'h00555, 8'h90);
    chk("R6", {13'h0, mode}, 16'h0);
    cmd(8'h90);
    wr(20'h00123, 8'h77);
    chk("R6", {13'h0, mode}, 16'h0);

    // R12 inhibited cycles do not break a sequence
    unl();
    wr_inh(20'h002AB, 8'h00, 1'b1);
    wr_inh(20'h00001, 8'h13, 1'b0);
    wr(20'h00555, 8'h90);
    chk("R12", {13'h0, mode}, 16'h1);
    wr(20'h0, 8'hF0);

    // R3 program; R7 writes ignored while busy; R10 F0 without fail ignored
    push(0, 20'h31234, 8'h5A, 16'h0, "R3");
    prog(20'h31234, 8'h5A);
    chk("R3", {13'h0, mode}, 16'h2);
    wr(20'h0, 8'hF0);
    cmd(8'h90);
    chk("R7", {13'h0, mode}, 16'h2);
    done();
    chk("R7", {13'h0, mode}, 16'h0);

    // R10 fail then abort
    push(0, 20'h20000, 8'h01, 16'h0, "R10");
    prog(20'h20000, 8'h01);
    @(negedge clk); eng_fail = 1'b1;
    @(negedge clk); eng_fail = 1'b0;
    chk("R10", {13'h0, mode}, 16'h2);
    wr(20'h0, 8'hF0);
    chk("R10", {13'h0, mode}, 16'h0);

    // R13 program into locked group 2 (sectors 4 and 5)
    push(2, 20'h0, 8'h0, 16'h0, "R13");
    prog(20'h40000, 8'h11);
    chk("R13", {13'h0, mode}, 16'h0);

    // R4 chip erase skips locked sectors; R7 suspend ignored for chip erase
    push(1, 20'h0, 8'h0, 16'hFFCF, "R4");
    cmd(8'h80); unl(); wr(20'h00555, 8'h10);
    chk("R4", {13'h0, mode}, 16'h3);
    wr(20'h0, 8'hB0);
    chk("R7", {13'h0, mode}, 16'h3);
    done();
    chk("R4", {13'h0, mode}, 16'h0);

    // R5 sector erase window with added sectors; R13 locked add refused
    serase(20'h70000);
    chk("R5", {13'h0, mode}, 16'h4);
    wr(20'h90000, 8'h30);
    push(2, 20'h0, 8'h0, 16'h0, "R13");
    wr(20'h50000, 8'h30);
    push(1, 20'h0, 8'h0, 16'h0280, "R5");
    repeat (WIN + 3) @(negedge clk);
    chk("R5", {13'h0, mode}, 16'h3);
    chk("R5", exp_q.size(), 16'h0);

    // R8 suspend; R9 program inside and outside the erase mask
    wr(20'h0, 8'hB0);
    chk("R8", {13'h0, mode}, 16'h5);
    chk("R8", {15'h0, eng_hold}, 16'h1);
    push(2, 20'h0, 8'h0, 16'h0, "R9");
    prog(20'h90010, 8'h22);
    chk("R9", {13'h0, mode}, 16'h5);
    cmd(8'h90);
    chk("R9", {13'h0, mode}, 16'h5);
    push(0, 20'h10020, 8'h3C, 16'h0, "R9");
    prog(20'h10020, 8'h3C);
    chk("R9", {13'h0, mode}, 16'h2);
    chk("R9", {15'h0, eng_hold}, 16'h1);
    done();
    chk("R9", {13'h0, mode}, 16'h5);
    wr(20'h0, 8'h30);
    chk("R8", {13'h0, mode}, 16'h3);
    chk("R8", {15'h0, eng_hold}, 16'h0);
    wr(20'h0, 8'hB0);
    chk("R8", {13'h0, mode}, 16'h5);
    wr(20'h0, 8'h30);
    wr(20'h0, 8'hF0);
    chk("R10", {13'h0, mode}, 16'h3);
    done();
    chk("R8", {13'h0, mode}, 16'h0);

    // R8 resume in read mode has no effect
    wr(20'h0, 8'h30);
    chk("R8", {13'h0, mode}, 16'h0);

    // R8 suspend during the window; resume starts the erase
    serase(20'h20000);
    wr(20'h0, 8'hB0);
    chk("R8", {13'h0, mode}, 16'h5);
    push(1, 20'h0, 8'h0, 16'h0004, "R8");
    wr(20'h0, 8'h30);
    chk("R8", {13'h0, mode}, 16'h3);
    done();

    // R6 other write cancels the window
    serase(20'h30000);
    wr(20'h00555, 8'hAA);
    chk("R6", {13'h0, mode}, 16'h0);
    repeat (WIN + 3) @(negedge clk);
    chk("R6", {13'h0, mode}, 16'h0);

    repeat (3) @(negedge clk);
    chk("R6", exp_q.size(), 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule